// File: doc/BRIEF.md
# Multiplexed Display Scan Sequencer

This block turns a free-running base clock into the time-shared drive of an eight-position common-cathode character display. A prescaler divides the base clock by 64. Each time it wraps, a position counter steps to the next of the eight positions. On every cycle, the position counter gives the read address of an external character store. The 6-bit code that comes back is looked up in a font table to give 17 segment enables: sixteen stroke segments plus a decimal point. The active position is decoded to a one-hot enable.

The first base cycle of every position slot is a blanking cycle, so the display does not ghost while the lit position changes. When the store is being written, the write address takes over the store's read port. Both output buses are then muted, but the scan keeps counting. When the run input is pulled low, the display goes dark and both dividers are held at zero. The external store keeps its contents, and the scan starts again from the leftmost position.

Top module: `disp_scan_top`

## Requirements
- R1: While `rst_n` is low, `pos_en` and `seg_en` are all zero, and the scan restarts at position 0 with the prescaler at 0 after reset is released.
- R2: Each position slot lasts exactly 64 base cycles. The position advances by one when the prescaler wraps from 63 to 0, and it wraps from 7 to 0.
- R3: `pos_en` is active-high and never has more than one bit set. Bit p (bit 0 = leftmost) lights position p.
- R4: The prescaler state 0 is the blanking cycle. The outputs that follow it have every `pos_en` and `seg_en` bit off, so 63 of the 64 cycles of each slot are lit.
- R5: `seg_en` equals the font entry of the code read at the lit position. It is registered on the same edge as `pos_en`, so both appear one cycle after the scan state that produced them.
- R6: With the default font, code 6'b100000 gives all 17 segment enables off. Every other code gives at least one segment on.
- R7: `mem_addr` equals the position counter. During a qualifying write it equals `wr_addr` instead.
- R8: A write qualifies when `wr_req` is high and either `wr_seq_mode` is 0 (random access), or `wr_seq_mode` is 1 with `wr_ser_en` high and `wr_full` low. A qualifying write forces `pos_en` and `seg_en` to zero on the next edge. A non-qualifying request leaves the outputs as they would otherwise be. The scan counters keep running in both cases.
- R9: While `scan_en` is low, the prescaler and position counter are held at zero and the outputs are zero. After `scan_en` returns high, the first lit output is position 0, two cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Run enable; low shuts the scan down and clears the dividers |
| wr_req | input | 1 | Store write in progress |
| wr_seq_mode | input | 1 | 1 = sequential entry mode, 0 = random access mode |
| wr_ser_en | input | 1 | Sequential-mode serial enable |
| wr_full | input | 1 | Sequential-mode full flag |
| wr_addr | input | 3 | Store address used by a write |
| mem_code | input | 6 | Character code read from the store at `mem_addr` |
| mem_addr | output | 3 | Store read/write address |
| pos_en | output | 8 | One-hot position enables, bit 0 leftmost |
| seg_en | output | 17 | Segment enables, decimal point in bit 16's table slot as the font defines |

## Verification
A prescaler that is off by one shows up as a lit slot of 62 or 64 cycles instead of 63, or as a position that changes one cycle early. This is visible in the first frame after reset, within 70 cycles. A wrong position count or decode lights the wrong `pos_en` bit, or pairs a segment pattern with the wrong position, at the first lit cycle of that slot. A wrong write qualification shows at once: the outputs stay dark during a non-qualifying sequential request, or stay lit during a qualifying one, on the very next edge. A shutdown that does not clear the dividers shows as a first lit position other than 0 after release.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

  localparam int FONT_CODE_W = 6;
  localparam int FONT_CODES  = 1 << FONT_CODE_W;
  localparam int FONT_SEGS   = 17;
  localparam logic [FONT_CODE_W-1:0] BLANK_CODE = 6'b100000;

  // One font entry: code bits, inverted code bits, low five code bits.
  // The blank code is forced dark.
  function automatic logic [FONT_SEGS-1:0] glyph_of(input logic [FONT_CODE_W-1:0] code);
    if (code == BLANK_CODE) return '0;
    return {code, ~code, code[4:0]};
  endfunction

  // Whole table, packed with entry k at bits [k*FONT_SEGS +: FONT_SEGS].
  function automatic logic [FONT_CODES*FONT_SEGS-1:0] font_default();
    logic [FONT_CODES*FONT_SEGS-1:0] tbl;
    tbl = '0;
    for (int k = 0; k < FONT_CODES; k++) begin
      tbl[k*FONT_SEGS +: FONT_SEGS] = glyph_of(FONT_CODE_W'(k));
    end
    return tbl;
  endfunction

  // Next value of a wrapping counter.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v == last) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/disp_scan_divider.sv
module disp_scan_divider #(
  parameter int PRESCALE  = 64,
  parameter int POSITIONS = 8,
  localparam int PRE_W = $clog2(PRESCALE),
  localparam int POS_W = $clog2(POSITIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [POS_W-1:0] pos_cnt,
  output logic             slot_end
);
  import disp_scan_pkg::*;

  localparam int unsigned PRE_LAST = PRESCALE - 1;
  localparam int unsigned POS_LAST = POSITIONS - 1;

  assign slot_end = (pre_cnt == PRE_W'(PRE_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pos_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      pos_cnt <= '0;
    end else begin
      pre_cnt <= PRE_W'(wrap_inc(int'(pre_cnt), PRE_LAST));
      if (slot_end) pos_cnt <= POS_W'(wrap_inc(int'(pos_cnt), POS_LAST));
    end
  end

endmodule

// File: rtl/disp_scan_arbiter.sv
module disp_scan_arbiter #(
  parameter int POS_W = 3
) (
  input  logic             wr_req,
  input  logic             wr_seq_mode,
  input  logic             wr_ser_en,
  input  logic             wr_full,
  input  logic [POS_W-1:0] wr_addr,
  input  logic [POS_W-1:0] pos_cnt,
  output logic             wr_take,
  output logic [POS_W-1:0] mem_addr
);

  always_comb begin
    if (wr_seq_mode) wr_take = wr_req && wr_ser_en && !wr_full;
    else             wr_take = wr_req;
    mem_addr = wr_take ? wr_addr : pos_cnt;
  end

endmodule

// File: rtl/disp_scan_drive.sv
module disp_scan_drive #(
  parameter int POSITIONS = 8,
  parameter int CODE_W    = 6,
  parameter int SEG_W     = 17,
  parameter logic [(1<<CODE_W)*SEG_W-1:0] FONT_TABLE = '0,
  localparam int POS_W = $clog2(POSITIONS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 show,
  input  logic [POS_W-1:0]     pos_cnt,
  input  logic [CODE_W-1:0]    mem_code,
  output logic [POSITIONS-1:0] pos_en,
  output logic [SEG_W-1:0]     seg_en
);

  logic [POSITIONS-1:0] pos_dec;
  logic [SEG_W-1:0]     glyph;

  for (genvar p = 0; p < POSITIONS; p++) begin : g_dec
    assign pos_dec[p] = show && (pos_cnt == POS_W'(p));
  end

  assign glyph = FONT_TABLE[int'(mem_code)*SEG_W +: SEG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_en <= '0;
      seg_en <= '0;
    end else begin
      pos_en <= pos_dec;
      seg_en <= show ? glyph : '0;
    end
  end

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top #(
  parameter int PRESCALE  = 64,
  parameter int POSITIONS = 8,
  parameter int CODE_W    = disp_scan_pkg::FONT_CODE_W,
  parameter int SEG_W     = disp_scan_pkg::FONT_SEGS,
  parameter logic [(1<<CODE_W)*SEG_W-1:0] FONT_TABLE = disp_scan_pkg::font_default(),
  localparam int POS_W = $clog2(POSITIONS),
  localparam int PRE_W = $clog2(PRESCALE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 wr_req,
  input  logic                 wr_seq_mode,
  input  logic                 wr_ser_en,
  input  logic                 wr_full,
  input  logic [POS_W-1:0]     wr_addr,
  input  logic [CODE_W-1:0]    mem_code,
  output logic [POS_W-1:0]     mem_addr,
  output logic [POSITIONS-1:0] pos_en,
  output logic [SEG_W-1:0]     seg_en
);

  // Named internal events, visible to the bound checker.
  logic [PRE_W-1:0] pre_cnt;
  logic [POS_W-1:0] pos_cnt;
  logic             slot_end;
  logic             wr_take;
  logic             blank_w;
  logic             show_w;

  assign blank_w = (pre_cnt == '0);
  assign show_w  = scan_en && !wr_take && !blank_w;

  disp_scan_divider #(.PRESCALE(PRESCALE), .POSITIONS(POSITIONS)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (scan_en),
    .pre_cnt  (pre_cnt),
    .pos_cnt  (pos_cnt),
    .slot_end (slot_end)
  );

  disp_scan_arbiter #(.POS_W(POS_W)) u_arb (
    .wr_req      (wr_req),
    .wr_seq_mode (wr_seq_mode),
    .wr_ser_en   (wr_ser_en),
    .wr_full     (wr_full),
    .wr_addr     (wr_addr),
    .pos_cnt     (pos_cnt),
    .wr_take     (wr_take),
    .mem_addr    (mem_addr)
  );

  disp_scan_drive #(
    .POSITIONS  (POSITIONS),
    .CODE_W     (CODE_W),
    .SEG_W      (SEG_W),
    .FONT_TABLE (FONT_TABLE)
  ) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .show     (show_w),
    .pos_cnt  (pos_cnt),
    .mem_code (mem_code),
    .pos_en   (pos_en),
    .seg_en   (seg_en)
  );

endmodule

// File: rtl/disp_scan_chk.sv
module disp_scan_chk #(
  parameter int PRESCALE  = 64,
  parameter int POSITIONS = 8,
  parameter int SEG_W     = 17,
  localparam int POS_W = $clog2(POSITIONS),
  localparam int PRE_W = $clog2(PRESCALE)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scan_en,
  input logic                 wr_take,
  input logic [POS_W-1:0]     wr_addr,
  input logic [PRE_W-1:0]     pre_cnt,
  input logic [POS_W-1:0]     pos_cnt,
  input logic [POS_W-1:0]     mem_addr,
  input logic [POSITIONS-1:0] pos_en,
  input logic [SEG_W-1:0]     seg_en
);

  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(POSITIONS - 1);

  assert_pos_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && pre_cnt == PRE_LAST) |=>
      pos_cnt == (($past(pos_cnt) == POS_LAST) ? '0 : POS_W'($past(pos_cnt) + 1'b1)));

  assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && pre_cnt != PRE_LAST) |=> $stable(pos_cnt));

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pos_en));

  assert_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt == '0) |=> (pos_en == '0 && seg_en == '0));

  assert_addr_mux_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr == (wr_take ? wr_addr : pos_cnt));

  assert_write_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (pos_en == '0 && seg_en == '0));

  assert_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (pre_cnt == '0 && pos_cnt == '0 && pos_en == '0 && seg_en == '0));

endmodule

bind disp_scan_top disp_scan_chk #(
  .PRESCALE  (PRESCALE),
  .POSITIONS (POSITIONS),
  .SEG_W     (SEG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .wr_take  (wr_take),
  .wr_addr  (wr_addr),
  .pre_cnt  (pre_cnt),
  .pos_cnt  (pos_cnt),
  .mem_addr (mem_addr),
  .pos_en   (pos_en),
  .seg_en   (seg_en)
);

// File: tb/test_disp_scan_top.sv
module test_disp_scan_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic        wr_req = 1'b0;
  logic        wr_seq_mode = 1'b0;
  logic        wr_ser_en = 1'b0;
  logic        wr_full = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [5:0]  mem_code;
  logic [2:0]  mem_addr;
  logic [7:0]  pos_en;
  logic [16:0] seg_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int m_pre = 0;
  int m_pos = 0;

  logic [5:0] store [8];
  assign mem_code = store[mem_addr];

  always #4 clk = ~clk;

  disp_scan_top i_disp_scan_top (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .wr_req(wr_req),
    .wr_seq_mode(wr_seq_mode), .wr_ser_en(wr_ser_en), .wr_full(wr_full),
    .wr_addr(wr_addr), .mem_code(mem_code), .mem_addr(mem_addr),
    .pos_en(pos_en), .seg_en(seg_en)
  );

  // Font restated: blank code dark, else code / complement / low five bits.
  function automatic logic [16:0] ref_glyph(input logic [5:0] c);
    logic [16:0] g;
    if (c == 6'd32) return 17'd0;
    g = 17'(c) << 11;
    g = g | (17'(6'd63 - c) << 5);
    g = g | 17'(c % 32);
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One base cycle: predict, clock, compare at the following negedge.
  task automatic step();
    bit take;
    logic [7:0]  ep;
    logic [16:0] es;
    logic [2:0]  ea;
    #1;
    take = wr_req && (!wr_seq_mode || (wr_ser_en && !wr_full));
    ea = take ? wr_addr : 3'(m_pos);
    check(mem_addr == ea, "R7 mem_addr", 32'(mem_addr), 32'(ea));
    if (!scan_en || take || m_pre == 0) begin
      ep = 8'd0; es = 17'd0;
    end else begin
      ep = 8'd1 << m_pos;
      es = ref_glyph(store[m_pos]);
    end
    @(posedge clk);
    if (!scan_en) begin
      m_pre = 0; m_pos = 0;
    end else if (m_pre == 63) begin
      m_pre = 0; m_pos = (m_pos + 1) % 8;
    end else begin
      m_pre = m_pre + 1;
    end
    @(negedge clk);
    check(pos_en == ep, take ? "R8 pos_en" : "R3 pos_en", 32'(pos_en), 32'(ep));
    check(seg_en == es, take ? "R8 seg_en" : "R5 seg_en", 32'(seg_en), 32'(es));
  endtask

  // {scan_en, wr_req, seq_mode, ser_en, full, wr_addr[2:0], cycles[11:0]}
  localparam logic [19:0] PHASES [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 12'd600},  // free scan R2 R4 R5
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5, 12'd5},    // random write R7 R8
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 12'd100},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 12'd4},    // qualifying sequential write R8
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd6, 12'd70},   // serial enable low: not qualifying R8
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 12'd70},   // full flag high: not qualifying R8
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 12'd10},   // shutdown R9
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 12'd600}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lit0;
    int hits3;
    int dark3;
    int wait_n;
    store[0] = 6'h11; store[1] = 6'h2A; store[2] = 6'h05; store[3] = 6'h20;
    store[4] = 6'h3F; store[5] = 6'h00; store[6] = 6'h19; store[7] = 6'h33;

    // R1: reset state
    repeat (3) @(negedge clk);
    scan_en = 1'b1;
    @(negedge clk);
    check(pos_en == 8'd0, "R1 pos_en in reset", 32'(pos_en), 32'd0);
    check(seg_en == 17'd0, "R1 seg_en in reset", 32'(seg_en), 32'd0);
    rst_n = 1'b1;
    m_pre = 0; m_pos = 0;

    // R2/R4: first slot lit 63 of 64 cycles for position 0
    lit0 = 0;
    for (int i = 0; i < 70; i++) begin
      step();
      if (pos_en == 8'h01) lit0++;
    end
    check(lit0 == 63, "R2 R4 lit cycles of slot 0", 32'(lit0), 32'd63);

    // table walk
    for (int ph = 0; ph < 8; ph++) begin
      scan_en     = PHASES[ph][19];
      wr_req      = PHASES[ph][18];
      wr_seq_mode = PHASES[ph][17];
      wr_ser_en   = PHASES[ph][16];
      wr_full     = PHASES[ph][15];
      wr_addr     = PHASES[ph][14:12];
      for (int c = 0; c < int'(PHASES[ph][11:0]); c++) step();
    end

    // R6: blank code at position 3 lights no segment
    hits3 = 0; dark3 = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (pos_en == 8'h08) begin
        hits3++;
        if (seg_en == 17'd0) dark3++;
      end
    end
    check(hits3 > 0, "R6 position 3 lit", 32'(hits3), 32'd63);
    check(dark3 == hits3, "R6 blank code dark", 32'(dark3), 32'(hits3));
    check(ref_glyph(6'h00) != 17'd0, "R6 code 0 visible", 32'(ref_glyph(6'h00)), 32'h1);

    // R9: shutdown then restart at position 0 after two cycles
    scan_en = 1'b0;
    repeat (5) step();
    check(pos_en == 8'd0, "R9 dark in shutdown", 32'(pos_en), 32'd0);
    scan_en = 1'b1;
    wait_n = 0;
    for (int i = 0; i < 70; i++) begin
      step();
      wait_n++;
      if (pos_en != 8'd0) break;
    end
    check(pos_en == 8'h01, "R9 first lit position", 32'(pos_en), 32'h01);
    check(wait_n == 2, "R9 restart latency", 32'(wait_n), 32'd2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule